// File: doc/BRIEF.md
# Per-Event Interrupt Source Controller

This block gathers a small set of event inputs and turns them into one interrupt request. At build time each event is assigned a trigger mode: level, rising edge or falling edge. Firmware reaches the block through a narrow register bus. That bus offers three views:

- a read-only view of the raw input levels;
- a set of sticky pending flags, which are cleared by writing ones to them;
- an enable mask that selects which pending flags drive the interrupt line.

A level-mode event behaves differently from the edge modes. It sets its pending flag again on every clock for as long as its input stays high. Clearing it therefore only takes effect once the source has gone quiet. An edge-mode event sets its flag once per qualifying transition. After that flag is cleared, it stays clear until the next transition.

The register bus is a single-cycle write strobe with an address and write data. Read data is a combinational function of the address.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, pending and enable read zero and `irq_o` is low. An input that is already high, or that changes, during reset or on the first clock after reset does not count as an edge.
- R2: Offset 0 reads the raw level of every event input, with bit i belonging to event i and the upper bits reading zero. Writes to offset 0 change nothing.
- R3: Offset 2 is the enable mask. Written bits read back on the next cycle. While the mask is all zero, `irq_o` stays low whatever is pending.
- R4: `irq_o` is high exactly when some pending bit and its enable bit are both set. It follows the registers without an extra cycle of delay.
- R5: A level-mode event whose input is high sets its pending bit on every clock. A clear has no lasting effect while the input is high, and it takes effect once the input is low.
- R6: A rising-edge event sets its pending bit when its input goes from low to high. After that bit is cleared, it stays clear while the input remains high. A falling transition does not set it.
- R7: A falling-edge event sets its pending bit when its input goes from high to low. A rising transition does not set it.
- R8: Writing offset 1 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R9: When a clear and a new trigger for the same event fall in the same cycle, the pending bit ends up set.
- R10: Offset 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event inputs, bit i is event i |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Register offset: 0 status, 1 pending, 2 enable |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with three events on an 8-bit bus. Event 0 is in level mode, event 1 in rising-edge mode and event 2 in falling-edge mode. With only three inputs, every pair of consecutive input patterns can be swept under every one of the eight enable masks. This reaches each edge kind on each mode, collisions between clears and triggers, and the full interrupt-mask truth table. A cycle-level model in the bench then follows a long random run of mixed register accesses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_RISE  = 2'd1,
    EVT_FALL  = 2'd2
  } evt_mode_e;

  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_PEND   = 1;
  localparam int unsigned REG_EN     = 2;

endpackage

// File: rtl/evt_trig_unit.sv
module evt_trig_unit
  import evt_irq_pkg::*;
#(
  parameter evt_mode_e MODE = EVT_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic trig_o
);

  logic prev_q;
  logic armed_q;

  // armed_q blocks an edge on the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= evt_i;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (MODE)
      EVT_RISE: trig_o = armed_q & evt_i & ~prev_q;
      EVT_FALL: trig_o = armed_q & ~evt_i & prev_q;
      default:  trig_o = evt_i;
    endcase
  end

endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] trig_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] pend_o,
  output logic [NUM_EVT-1:0] en_o
);

  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // trigger overrides a same-cycle clear
      pend_q <= (pend_q & ~clr_i) | trig_i;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] pend_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] clr_o,
  output logic               en_wr_o,
  output logic [NUM_EVT-1:0] en_wdata_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  logic sel_pend;
  logic sel_en;
  logic unused_wdata;

  assign sel_pend = (addr_i == ADDR_W'(REG_PEND));
  assign sel_en   = (addr_i == ADDR_W'(REG_EN));

  assign clr_o      = (wr_en_i && sel_pend) ? wdata_i[NUM_EVT-1:0] : '0;
  assign en_wr_o    = wr_en_i && sel_en;
  assign en_wdata_o = wdata_i[NUM_EVT-1:0];

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_EVT];

  always_comb begin
    if (addr_i == ADDR_W'(REG_STATUS))  rdata_o = {{PAD_W{1'b0}}, status_i};
    else if (sel_pend)                  rdata_o = {{PAD_W{1'b0}}, pend_i};
    else if (sel_en)                    rdata_o = {{PAD_W{1'b0}}, en_i};
    else                                rdata_o = '0;
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned          NUM_EVT   = 3,
  parameter int unsigned          ADDR_W    = 2,
  parameter int unsigned          DATA_W    = 8,
  // two bits per event, event i at [2i+1:2i]
  parameter logic [2*NUM_EVT-1:0] EVT_MODES = {EVT_FALL, EVT_RISE, EVT_LEVEL}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] trig;
  logic [NUM_EVT-1:0] clr;
  logic               en_wr;
  logic [NUM_EVT-1:0] en_wdata;
  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] en_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam evt_mode_e MODE_I = evt_mode_e'(EVT_MODES[2*i +: 2]);
    evt_trig_unit #(.MODE(MODE_I)) u_trig (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[i]),
      .trig_o (trig[i])
    );
  end

  evt_pend_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .clr_i      (clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (en_wdata),
    .pend_o     (pend_q),
    .en_o       (en_q)
  );

  evt_reg_if #(
    .NUM_EVT (NUM_EVT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_i   (evt_i),
    .pend_i     (pend_q),
    .en_i       (en_q),
    .clr_o      (clr),
    .en_wr_o    (en_wr),
    .en_wdata_o (en_wdata),
    .rdata_o    (rdata_o)
  );

  assign irq_o = |(pend_q & en_q);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned          NUM_EVT   = 3,
  parameter int unsigned          ADDR_W    = 2,
  parameter int unsigned          DATA_W    = 8,
  parameter logic [2*NUM_EVT-1:0] EVT_MODES = {EVT_FALL, EVT_RISE, EVT_LEVEL}
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] pend_q,
  input logic [NUM_EVT-1:0] en_q
);

  logic unused_chk;
  assign unused_chk = ^wdata_i[DATA_W-1:NUM_EVT];

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (pend_q == '0 && en_q == '0 && !irq_o);
    end
  end

  // R2
  status_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(REG_STATUS) |-> rdata_o[NUM_EVT-1:0] == evt_i && (rdata_o >> NUM_EVT) == '0);

  // R3
  mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |-> !irq_o);

  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(REG_EN)) |=> $stable(en_q));

  // R10
  gap_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(3) |-> rdata_o == '0);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    localparam evt_mode_e MODE_I = evt_mode_e'(EVT_MODES[2*i +: 2]);

    // R8
    keep_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'(REG_PEND) && !wdata_i[i] && pend_q[i] |=> pend_q[i]);

    if (MODE_I == EVT_RISE) begin : g_rise
      // R6
      rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q[i]) |-> $past(evt_i[i]));
    end else if (MODE_I == EVT_FALL) begin : g_fall
      // R7
      fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q[i]) |-> !$past(evt_i[i]));
    end else begin : g_level
      // R5
      level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> pend_q[i]);
      // R5
      level_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == ADDR_W'(REG_PEND) && wdata_i[i] && !evt_i[i] |=> !pend_q[i]);
    end
  end

endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NUM_EVT   (NUM_EVT),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .EVT_MODES (EVT_MODES)
) u_chk (.*);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] evt;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;

  // model state; event 0 level, 1 rising, 2 falling
  logic [2:0] prev_m = '0;
  logic [2:0] pend_m = '0;
  logic [2:0] en_m   = '0;
  logic       armed_m = 1'b0;

  always #5 clk_i = ~clk_i;

  evt_irq_ctrl #(
    .NUM_EVT   (3),
    .ADDR_W    (2),
    .DATA_W    (8),
    .EVT_MODES (6'b10_01_00)
  ) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic step(input logic [2:0] e, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input string tag);
    logic [2:0] trig;
    logic [2:0] clr;
    logic [7:0] exp;
    evt = e; wr_en = w; addr = a; wdata = d;
    trig[0] = e[0];
    trig[1] = armed_m & e[1] & ~prev_m[1];
    trig[2] = armed_m & ~e[2] & prev_m[2];
    clr = (w && a == 2'd1) ? d[2:0] : 3'b000;
    pend_m = (pend_m & ~clr) | trig;
    if (w && a == 2'd2) en_m = d[2:0];
    prev_m = e;
    armed_m = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en = 1'b0;
    case (a)
      2'd0:    exp = {5'b0, e};
      2'd1:    exp = {5'b0, pend_m};
      2'd2:    exp = {5'b0, en_m};
      default: exp = 8'h00;
    endcase
    chk({tag, " rdata"}, rdata, exp);
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, |(pend_m & en_m)});
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; evt = 3'b010; wr_en = 1'b0; addr = 2'd1; wdata = '0;
    #2;
    chk("R1 reset pend", rdata, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // rising input already high at release: no edge
    repeat (3) step(3'b010, 1'b0, 2'd1, 8'h00, "R1");
    step(3'b010, 1'b0, 2'd2, 8'h00, "R1");

    // status sweep and ignored status writes
    for (int p = 0; p < 8; p++) step(3'(p), 1'b0, 2'd0, 8'h00, "R2");
    for (int p = 0; p < 8; p++) begin
      step(3'(p), 1'b1, 2'd0, 8'hFF, "R2");
      step(3'(p), 1'b0, 2'd2, 8'h00, "R2");
    end

    // masked activity, then unmasking
    step(3'b000, 1'b1, 2'd1, 8'hFF, "R8");
    step(3'b101, 1'b0, 2'd0, 8'h00, "R3");
    step(3'b101, 1'b0, 2'd1, 8'h00, "R3");
    step(3'b101, 1'b1, 2'd2, 8'h07, "R3");
    step(3'b101, 1'b0, 2'd2, 8'h00, "R4");

    // level clear while high, then low
    step(3'b101, 1'b1, 2'd1, 8'h01, "R5");
    step(3'b101, 1'b0, 2'd1, 8'h00, "R5");
    step(3'b100, 1'b1, 2'd1, 8'h01, "R5");
    step(3'b100, 1'b0, 2'd1, 8'h00, "R5");

    // rising edge
    step(3'b110, 1'b0, 2'd1, 8'h00, "R6");
    step(3'b110, 1'b1, 2'd1, 8'h02, "R6");
    step(3'b110, 1'b0, 2'd1, 8'h00, "R6");
    step(3'b100, 1'b0, 2'd1, 8'h00, "R6");

    // falling edge
    step(3'b000, 1'b0, 2'd1, 8'h00, "R7");
    step(3'b000, 1'b1, 2'd1, 8'h04, "R7");
    step(3'b100, 1'b0, 2'd1, 8'h00, "R7");

    // write zero keeps, then clear everything
    step(3'b100, 1'b1, 2'd1, 8'h00, "R8");
    step(3'b100, 1'b1, 2'd1, 8'h07, "R8");
    step(3'b100, 1'b0, 2'd1, 8'h00, "R8");

    // clear colliding with new triggers
    step(3'b010, 1'b1, 2'd1, 8'h06, "R9");
    step(3'b000, 1'b1, 2'd1, 8'h04, "R9");
    step(3'b011, 1'b1, 2'd1, 8'h03, "R9");

    // unused offset
    step(3'b000, 1'b1, 2'd3, 8'hFF, "R10");
    step(3'b000, 1'b0, 2'd3, 8'h00, "R10");
    step(3'b000, 1'b0, 2'd2, 8'h00, "R10");
    step(3'b000, 1'b0, 2'd1, 8'h00, "R10");

    // every mask against every pair of input patterns
    for (int m = 0; m < 8; m++) begin
      step(3'b000, 1'b1, 2'd2, 8'(m), "R3");
      for (int x = 0; x < 64; x++) begin
        step(3'(x), 1'b0, 2'd1, 8'h00, "R4");
        step(3'(x >> 3), 1'b1, 2'd1, 8'(3'(x) ^ 3'(x >> 3)), "R4");
      end
    end

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      step(3'($urandom), 1'($urandom), 2'($urandom), 8'($urandom), "R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule